// File: doc/BRIEF.md
# SDRAM Row-Column Access Sequencer

This block turns one read or write request on a linear halfword offset into the two-step command sequence an SDRAM expects. On acceptance it drives a row-activate command carrying the bank and the row. It then holds the device in no-operation for a programmable RAS-to-CAS delay. After that it drives the column command. The column command also carries the direction: write or read. A one-cycle done pulse follows. Row and column share one 12-line multiplexed address bus.

The point where the offset is split into column, row and bank fields moves with a 2-bit column-width setting. This lets one sequencer serve devices with 8, 9 or 10 column address lines. Refresh, mode-register setup, precharge and burst data movement belong to neighbouring logic. A request is taken only while the sequencer is idle. The direction, offset and both settings are sampled at that moment.

Top module: `sdram_rc_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, csN, rasN, casN and weN are all 1, done is 0 and reqReady is 1.
- R2: While idle and with no request, the pins show deselect: csN, rasN, casN and weN all 1, ba and sdAddr all 0, done 0.
- R3: In the cycle after a clock edge that sees reqValid and reqReady both high, the pins show activate: {csN,rasN,casN,weN} = 4'b0011. ba carries the bank field and sdAddr carries the row field.
- R4: Between activate and the column command, each cycle shows no-operation, {csN,rasN,casN,weN} = 4'b0111. There are exactly T-1 such cycles, where T is the effective delay.
- R5: The column command comes exactly T cycles after activate. A write shows {csN,rasN,casN,weN} = 4'b0100 and a read shows 4'b0101. ba repeats the bank field, and sdAddr carries the column field zero-extended to 12 bits.
- R6: The effective delay T is cfgTrcd clamped to the range 2..4. cfgTrcd values 0 and 1 give 2, and values 5, 6 and 7 give 4.
- R7: cfgColW selects the column width C: 2'b00 gives 8, 2'b01 gives 9, 2'b10 gives 10, and 2'b11 is treated as 10. The column field is offset bits [C-1:0]. The row field is offset bits [C+11:C]. The bank field is offset bits [C+13:C+12].
- R8: done is 1 in exactly the one cycle after the column command, and 0 in every other cycle.
- R9: reqReady is 0 from the activate cycle through the done cycle. A request held during that time starts no command. reqReady returns to 1 in the cycle after done.
- R10: Offset, direction, cfgColW and cfgTrcd are sampled only at acceptance. Changing them during an access alters neither its timing nor its addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Sequencer idle and able to accept |
| reqAddr | input | 24 | Linear halfword offset |
| reqWrite | input | 1 | 1 = write, 0 = read |
| cfgColW | input | 2 | Column width select |
| cfgTrcd | input | 3 | RAS-to-CAS delay in clocks, clamped to 2..4 |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| sdAddr | output | 12 | Multiplexed row/column address |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case is a request or a setting that changes while an access is already in flight. Neither may leak into the current access. The stimulus therefore keeps reqValid high through the whole busy window with a different offset and direction, and changes cfgColW and cfgTrcd right after acceptance. Every access is then checked against values computed from what was sampled at acceptance. The stimulus also checks that the idle cycle after done shows deselect, not a stray activate. The sweep covers all four column-width codes and all eight delay codes, both directions and several offset patterns.

// File: rtl/sdram_rc_pkg.sv
package sdram_rc_pkg;
  localparam int BANK_W  = 2;
  localparam int BUS_W   = 12;
  localparam int COL_MIN = 8;
  localparam int COL_MAX = 10;
  localparam int ADDR_W  = BANK_W + BUS_W + COL_MAX;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_WAIT,
    ST_COL,
    ST_DONE
  } seqState_t;

  typedef struct packed {
    logic capture;
    logic driveRow;
    logic driveCol;
  } pathStrobe_t;
endpackage

// File: rtl/sdram_rc_ctrl.sv
module sdram_rc_ctrl
  import sdram_rc_pkg::*;
#(
  parameter int TRCD_W   = 3,
  parameter int TRCD_MIN = 2,
  parameter int TRCD_MAX = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [TRCD_W-1:0] cfgTrcd,
  output logic              reqReady,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              done,
  output pathStrobe_t       strobe
);
  seqState_t         state, stateNext;
  logic [TRCD_W-1:0] trcdQ, trcdEff, waitCnt;

  // Clamp the requested delay into the supported window.
  always_comb begin
    if (cfgTrcd < TRCD_W'(TRCD_MIN))      trcdEff = TRCD_W'(TRCD_MIN);
    else if (cfgTrcd > TRCD_W'(TRCD_MAX)) trcdEff = TRCD_W'(TRCD_MAX);
    else                                  trcdEff = cfgTrcd;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (reqValid) stateNext = ST_ACT;
      ST_ACT:  stateNext = ST_WAIT;
      ST_WAIT: if (waitCnt == trcdQ - TRCD_W'(1)) stateNext = ST_COL;
      ST_COL:  stateNext = ST_DONE;
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      trcdQ   <= TRCD_W'(TRCD_MIN);
      waitCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE && reqValid) trcdQ <= trcdEff;
      if (state == ST_ACT)       waitCnt <= TRCD_W'(1);
      else if (state == ST_WAIT) waitCnt <= waitCnt + TRCD_W'(1);
    end
  end

  always_comb begin
    reqReady        = (state == ST_IDLE);
    csN             = !(state == ST_ACT || state == ST_WAIT || state == ST_COL);
    rasN            = (state != ST_ACT);
    casN            = (state != ST_COL);
    done            = (state == ST_DONE);
    strobe.capture  = (state == ST_IDLE) && reqValid;
    strobe.driveRow = (state == ST_ACT);
    strobe.driveCol = (state == ST_COL);
  end
endmodule

// File: rtl/sdram_rc_path.sv
module sdram_rc_path
  import sdram_rc_pkg::*;
#(
  parameter int ROW_W = BUS_W,
  parameter int CMIN  = COL_MIN,
  parameter int CMAX  = COL_MAX,
  parameter int BNK_W = BANK_W
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  pathStrobe_t                  strobe,
  input  logic [BNK_W+ROW_W+CMAX-1:0]  reqAddr,
  input  logic                         reqWrite,
  input  logic [1:0]                   cfgColW,
  output logic [BNK_W-1:0]             ba,
  output logic [ROW_W-1:0]             sdAddr,
  output logic                         weN
);
  localparam int NW = CMAX - CMIN + 1;

  logic [CMAX-1:0]  colCand  [NW];
  logic [ROW_W-1:0] rowCand  [NW];
  logic [BNK_W-1:0] bankCand [NW];

  // One candidate split per supported column width.
  for (genvar g = 0; g < NW; g++) begin : g_split
    localparam int CW = CMIN + g;
    assign colCand[g]  = CMAX'(reqAddr[CW-1:0]);
    assign rowCand[g]  = reqAddr[CW+ROW_W-1:CW];
    assign bankCand[g] = reqAddr[CW+ROW_W+BNK_W-1:CW+ROW_W];
  end

  logic [1:0] sel;
  always_comb sel = (int'(cfgColW) >= NW) ? 2'(NW - 1) : cfgColW;

  logic [CMAX-1:0]  colQ;
  logic [ROW_W-1:0] rowQ;
  logic [BNK_W-1:0] bankQ;
  logic             writeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colQ   <= '0;
      rowQ   <= '0;
      bankQ  <= '0;
      writeQ <= 1'b0;
    end else if (strobe.capture) begin
      colQ   <= colCand[sel];
      rowQ   <= rowCand[sel];
      bankQ  <= bankCand[sel];
      writeQ <= reqWrite;
    end
  end

  always_comb begin
    ba     = (strobe.driveRow || strobe.driveCol) ? bankQ : '0;
    sdAddr = strobe.driveRow ? rowQ
           : strobe.driveCol ? ROW_W'(colQ)
           : '0;
    weN    = !(strobe.driveCol && writeQ);
  end
endmodule

// File: rtl/sdram_rc_seq.sv
module sdram_rc_seq
  import sdram_rc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [1:0]        cfgColW,
  input  logic [2:0]        cfgTrcd,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BANK_W-1:0] ba,
  output logic [BUS_W-1:0]  sdAddr,
  output logic              done
);
  pathStrobe_t strobe;

  sdram_rc_ctrl #(.TRCD_W(3), .TRCD_MIN(2), .TRCD_MAX(4)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .cfgTrcd(cfgTrcd),
    .reqReady(reqReady), .csN(csN), .rasN(rasN), .casN(casN),
    .done(done), .strobe(strobe)
  );

  sdram_rc_path #(.ROW_W(BUS_W), .CMIN(COL_MIN), .CMAX(COL_MAX), .BNK_W(BANK_W)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .cfgColW(cfgColW), .ba(ba), .sdAddr(sdAddr), .weN(weN)
  );
endmodule

// File: rtl/sdram_rc_seq_chk.sv
module sdram_rc_seq_chk (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqReady,
  input logic csN,
  input logic rasN,
  input logic casN,
  input logic weN,
  input logic done
);
  logic       actCmd, colCmd;
  logic [3:0] sinceAct;

  assign actCmd = !csN && !rasN && casN && weN;
  assign colCmd = !csN && rasN && !casN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceAct <= '0;
    else if (actCmd)           sinceAct <= 4'd1;
    else if (sinceAct != 4'hF) sinceAct <= sinceAct + 4'd1;
  end

  p_act_after_accept_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> actCmd);

  p_nop_wait_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && rasN && casN) |-> weN);

  p_col_gap_r5: assert property (@(posedge clk) disable iff (!rstN)
    colCmd |-> (sinceAct >= 4'd2 && sinceAct <= 4'd4));

  p_done_after_col_r8: assert property (@(posedge clk) disable iff (!rstN)
    colCmd |=> done);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  p_deselect_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (csN && !done));
endmodule

bind sdram_rc_seq sdram_rc_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .csN(csN), .rasN(rasN), .casN(casN), .weN(weN), .done(done)
);

// File: tb/sdram_rc_seq_bench.sv
module sdram_rc_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [23:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic [1:0]  cfgColW = 2'b00;
  logic [2:0]  cfgTrcd = 3'd2;
  logic        csN, rasN, casN, weN, done;
  logic [1:0]  ba;
  logic [11:0] sdAddr;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_rc_seq u_sdram_rc_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .cfgColW(cfgColW), .cfgTrcd(cfgTrcd),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN), .ba(ba), .sdAddr(sdAddr),
    .done(done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int pins();
    return int'({csN, rasN, casN, weN});
  endfunction

  // One access; called at a negedge with the design idle.
  task automatic access(input logic [23:0] a, input bit wr, input logic [1:0] cw,
                        input logic [2:0] tr);
    int c, t, col, row, bnk;
    c   = (cw == 2'b00) ? 8 : (cw == 2'b01) ? 9 : 10;
    t   = (tr < 3'd2) ? 2 : (tr > 3'd4) ? 4 : int'(tr);
    col = int'(a) & ((1 << c) - 1);
    row = (int'(a) >> c) & 12'hFFF;
    bnk = (int'(a) >> (c + 12)) & 3;
    reqAddr = a; reqWrite = wr; cfgColW = cw; cfgTrcd = tr; reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    // R10 / R9: disturb inputs and hold a request while busy
    reqAddr = ~a; reqWrite = !wr; cfgColW = cw + 2'd1; cfgTrcd = tr + 3'd3;
    chk("R3 act pins", pins(), 4'b0011);
    chk("R3 act bank", int'(ba), bnk);
    chk("R3/R7 act row", int'(sdAddr), row);
    chk("R9 ready low", int'(reqReady), 0);
    for (int i = 1; i < t; i++) begin
      @(negedge clk);
      chk("R4/R6/R10 nop pins", pins(), 4'b0111);
      chk("R9 ready low in wait", int'(reqReady), 0);
    end
    @(negedge clk);
    chk("R5/R6 col pins", pins(), wr ? 4'b0100 : 4'b0101);
    chk("R5 col bank", int'(ba), bnk);
    chk("R5/R7/R10 col addr", int'(sdAddr), col);
    chk("R8 no done at col", int'(done), 0);
    @(negedge clk);
    chk("R8 done pulse", int'(done), 1);
    chk("R9 ready low at done", int'(reqReady), 0);
    chk("R2 deselect at done", pins(), 4'b1111);
    reqValid = 1'b0;
    @(negedge clk);
    chk("R8 done single", int'(done), 0);
    chk("R9 ready back", int'(reqReady), 1);
    chk("R9 no stray cmd", pins(), 4'b1111);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [23:0] pats [4];
    pats[0] = 24'hFFFFFF; pats[1] = 24'h000000;
    pats[2] = 24'hA5C3E7; pats[3] = 24'h5A3C18;
    #(CLK_PERIOD * 2 + 1);
    chk("R1 reset pins", pins(), 4'b1111);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset ready", int'(reqReady), 1);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 post reset pins", pins(), 4'b1111);
    chk("R1 post reset ready", int'(reqReady), 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R2 idle pins", pins(), 4'b1111);
      chk("R2 idle ba", int'(ba), 0);
      chk("R2 idle addr", int'(sdAddr), 0);
      chk("R2 idle done", int'(done), 0);
    end
    for (int w = 0; w < 4; w++)
      for (int tr = 0; tr < 8; tr++)
        for (int d = 0; d < 2; d++)
          for (int p = 0; p < 4; p++)
            access(pats[p] ^ 24'(w * 24'h111111 + tr), bit'(d), 2'(w), 3'(tr));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule